// File: doc/BRIEF.md
# Dual-Channel Cosine Tone Generator

This block synthesises a cosine tone digitally and presents it as two 8-bit converter codes. Both channels share one 16-bit phase accumulator. On every clock the accumulator adds a programmable step, so the tone frequency is the clock frequency times the step divided by 65536. The upper accumulator bits address a quarter-wave cosine table. Each channel then shapes the shared sample on its own: an attenuation by a power of two, an optional 180-degree inversion, and a signed DC offset. The result is shifted to unsigned code space and clamped to 0..255.

Software drives the block through a single-word configuration write port and a direct-code write port for each channel. A channel shows its tone only while the shared tone switch and its own enable are both on. Otherwise it shows the code last written to its direct port. Writing a direct code also switches that channel's tone off.

Each channel runs a three-state mode machine. The states are DIRECT (enable clear), ARMED (enable set, shared switch off) and TONE (both set). The transitions are:
- *arm*: DIRECT to ARMED, when the enable is set while the shared switch will be off.
- *start*: DIRECT to TONE, when the enable is set while the shared switch will be on.
- *resume*: ARMED to TONE, when the shared switch turns on.
- *pause*: TONE to ARMED, when the shared switch turns off.
- *drop*: ARMED or TONE to DIRECT, on a direct write or when the enable is cleared.

Top module: `cosgen_tone_top`

## Requirements
- R1: A synchronous reset sets both outputs to 0x80 and clears the accumulator, the step and the shared switch. It puts each channel in DIRECT with scale 0, phase field 2, offset 0 and direct code 0x80.
- R2: While the shared switch is on, the accumulator adds the step every clock, modulo 65536. While the switch is off, the accumulator holds its value.
- R3: A configuration write selects its target with cfg_sel. Value 0 sets the shared switch from bit 0. Value 1 loads the 16-bit step. Value 2+c configures channel c: bit 0 is the enable, bits 2:1 the scale, bits 4:3 the phase field, and bits 15:8 the signed offset.
- R4: With k the top 6 accumulator bits, the raw sample is round(127*cos(2*pi*(k+0.5)/64)). It comes from a 16-entry quarter table with mirroring and sign handling.
- R5: Scale n shifts the sample arithmetically right by n, dividing the amplitude by 1, 2, 4 or 8 and rounding toward minus infinity.
- R6: A phase field of 3 negates the scaled sample. Any other value, including 2, leaves it unchanged.
- R7: The code is the shaped sample plus the signed offset plus 128, clamped to the range 0..255.
- R8: A channel outputs its tone code only while both the shared switch and its enable are set. Otherwise it outputs its direct code.
- R9: A direct write stores the code and clears the channel's enable. It takes priority over a configuration write to the same channel in the same cycle.
- R10: The outputs are registered. A write captured at clock edge E first shows on the output after edge E+1.
- R11: Each channel follows the DIRECT/ARMED/TONE state machine above. TONE is never held while the shared switch is off.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_sel | input | SEL_W (2) | Configuration target select |
| cfg_wdata | input | 16 | Configuration write data |
| dir_we | input | NCH (2) | Direct-code write strobe, one per channel |
| dir_code | input | NCH*8 | Direct codes, channel c in bits 8c+7:8c |
| dac_code | output | NCH*8 | Converter codes, channel c in bits 8c+7:8c |

## Verification
The bench targets the clamp at both ends: a positive offset on a full-scale peak, and a negative offset on an inverted peak. A design that wrapped instead of clamping would output a small code for the first case and a large code for the second.

It drives a direct write and a configuration enable in the same cycle. A design with the wrong priority would leave that channel toning.

It toggles the shared switch on armed channels and checks the accumulator hold. A design that kept stepping would come back at the wrong phase.

Sweeps at several steps, including 0xFFFF, expose three kinds of error: mirrored-quadrant index faults, a wrong sign in the second and third quarters, and a scale shift that rounds toward zero instead of toward minus infinity.

// File: rtl/cosgen_pkg.sv
package cosgen_pkg;

    // Shared widths
    localparam int CODE_W    = 8;   // converter code width
    localparam int STEP_W    = 16;  // phase accumulator / step width
    localparam int CFG_W     = 16;  // configuration word width
    localparam int QSEL_W    = 2;   // quadrant select bits
    localparam int LUT_IDX_W = 4;   // quarter-table index bits
    localparam int PTOP_W    = QSEL_W + LUT_IDX_W;
    localparam int SAMP_W    = 8;   // signed sample width
    localparam int SCALE_W   = 2;
    localparam int PHASE_W   = 2;

    // Field positions inside a channel configuration word
    localparam int F_EN      = 0;
    localparam int F_SCALE   = 1;
    localparam int F_PHASE   = 3;
    localparam int F_OFF     = 8;

    localparam logic [PHASE_W-1:0] PH_NORMAL = 2'd2;
    localparam logic [PHASE_W-1:0] PH_INVERT = 2'd3;
    localparam logic [CODE_W-1:0]  MIDSCALE  = 8'h80;

    typedef enum logic [1:0] {
        MODE_DIRECT = 2'd0,
        MODE_ARMED  = 2'd1,
        MODE_TONE   = 2'd2
    } ch_mode_e;

endpackage

// File: rtl/cosgen_phase_acc.sv
module cosgen_phase_acc
    import cosgen_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              run,
    input  logic [STEP_W-1:0] step,
    output logic [STEP_W-1:0] phase
);

    always_ff @(posedge clk) begin
        if (rst) begin
            phase <= '0;
        end else if (run) begin
            phase <= phase + step;
        end
    end

endmodule

// File: rtl/cosgen_cos_lut.sv
module cosgen_cos_lut
    import cosgen_pkg::*;
(
    input  logic [PTOP_W-1:0]        ptop,
    output logic signed [SAMP_W-1:0] sample
);

    logic [QSEL_W-1:0]    quad;
    logic [LUT_IDX_W-1:0] idx;
    logic [LUT_IDX_W-1:0] idx_m;
    logic [SAMP_W-2:0]    mag;
    logic                 neg;

    // 127*cos at the centre of each of 16 bins spanning a quarter turn
    function automatic logic [SAMP_W-2:0] quarter(input logic [LUT_IDX_W-1:0] i);
        logic [SAMP_W-2:0] v;
        unique case (i)
            4'd0:  v = 7'd127;
            4'd1:  v = 7'd126;
            4'd2:  v = 7'd123;
            4'd3:  v = 7'd120;
            4'd4:  v = 7'd115;
            4'd5:  v = 7'd109;
            4'd6:  v = 7'd102;
            4'd7:  v = 7'd94;
            4'd8:  v = 7'd85;
            4'd9:  v = 7'd76;
            4'd10: v = 7'd65;
            4'd11: v = 7'd54;
            4'd12: v = 7'd43;
            4'd13: v = 7'd31;
            4'd14: v = 7'd19;
            default: v = 7'd6;
        endcase
        return v;
    endfunction

    always_comb begin
        quad   = ptop[PTOP_W-1 -: QSEL_W];
        idx    = ptop[LUT_IDX_W-1:0];
        // odd quadrants run the table backwards
        idx_m  = quad[0] ? ~idx : idx;
        mag    = quarter(idx_m);
        // second and third quadrants are negative
        neg    = quad[1] ^ quad[0];
        sample = neg ? -$signed({1'b0, mag}) : $signed({1'b0, mag});
    end

endmodule

// File: rtl/cosgen_chan.sv
module cosgen_chan
    import cosgen_pkg::*;
(
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     glob_nxt,
    input  logic                     cfg_hit,
    input  logic                     cfg_en,
    input  logic [SCALE_W-1:0]       cfg_scale,
    input  logic [PHASE_W-1:0]       cfg_phase,
    input  logic [CODE_W-1:0]        cfg_off,
    input  logic                     dir_we,
    input  logic [CODE_W-1:0]        dir_code,
    input  logic signed [SAMP_W-1:0] sample,
    output ch_mode_e                 mode,
    output logic [CODE_W-1:0]        code
);

    localparam int SH_W  = SAMP_W + 1;
    localparam int SUM_W = SAMP_W + 2;

    ch_mode_e            mode_q, mode_d;
    logic [SCALE_W-1:0]  scale_q;
    logic [PHASE_W-1:0]  phase_q;
    logic [CODE_W-1:0]   off_q;
    logic [CODE_W-1:0]   dir_q;
    logic [CODE_W-1:0]   code_q;
    logic [CODE_W-1:0]   tone_code;

    logic signed [SH_W-1:0]  s_ext;
    logic signed [SH_W-1:0]  s_shift;
    logic signed [SH_W-1:0]  s_pol;
    logic signed [SUM_W-1:0] s_sum;

    // ---------------- mode state register ----------------
    always_ff @(posedge clk) begin
        if (rst) begin
            mode_q <= MODE_DIRECT;
        end else begin
            mode_q <= mode_d;
        end
    end

    // ---------------- mode transitions ----------------
    always_comb begin
        mode_d = mode_q;
        unique case (mode_q)
            MODE_DIRECT: begin
                if (!dir_we && cfg_hit && cfg_en) begin
                    mode_d = glob_nxt ? MODE_TONE : MODE_ARMED;   // start / arm
                end
            end
            MODE_ARMED: begin
                if (dir_we || (cfg_hit && !cfg_en)) begin
                    mode_d = MODE_DIRECT;                        // drop
                end else if (glob_nxt) begin
                    mode_d = MODE_TONE;                          // resume
                end
            end
            MODE_TONE: begin
                if (dir_we || (cfg_hit && !cfg_en)) begin
                    mode_d = MODE_DIRECT;                        // drop
                end else if (!glob_nxt) begin
                    mode_d = MODE_ARMED;                         // pause
                end
            end
            default: mode_d = MODE_DIRECT;
        endcase
    end

    // ---------------- per-channel setup registers ----------------
    always_ff @(posedge clk) begin
        if (rst) begin
            scale_q <= '0;
            phase_q <= PH_NORMAL;
            off_q   <= '0;
            dir_q   <= MIDSCALE;
        end else begin
            if (cfg_hit) begin
                scale_q <= cfg_scale;
                phase_q <= cfg_phase;
                off_q   <= cfg_off;
            end
            if (dir_we) begin
                dir_q <= dir_code;
            end
        end
    end

    // ---------------- waveform shaping ----------------
    always_comb begin
        s_ext   = {sample[SAMP_W-1], sample};
        s_shift = s_ext >>> scale_q;
        s_pol   = (phase_q == PH_INVERT) ? -s_shift : s_shift;
        s_sum   = {s_pol[SH_W-1], s_pol}
                + {{(SUM_W-CODE_W){off_q[CODE_W-1]}}, off_q}
                + SUM_W'(signed'(128));
        if (s_sum[SUM_W-1]) begin
            tone_code = '0;
        end else if (s_sum[SUM_W-2]) begin
            tone_code = '1;
        end else begin
            tone_code = s_sum[CODE_W-1:0];
        end
    end

    // ---------------- output register ----------------
    always_ff @(posedge clk) begin
        if (rst) begin
            code_q <= MIDSCALE;
        end else begin
            code_q <= (mode_q == MODE_TONE) ? tone_code : dir_q;
        end
    end

    assign mode = mode_q;
    assign code = code_q;

endmodule

// File: rtl/cosgen_tone_top.sv
module cosgen_tone_top
    import cosgen_pkg::*;
#(
    parameter int NCH   = 2,
    parameter int SEL_W = $clog2(NCH + 2)
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  cfg_we,
    input  logic [SEL_W-1:0]      cfg_sel,
    input  logic [CFG_W-1:0]      cfg_wdata,
    input  logic [NCH-1:0]        dir_we,
    input  logic [NCH*CODE_W-1:0] dir_code,
    output logic [NCH*CODE_W-1:0] dac_code
);

    localparam int SEL_GLOB = 0;
    localparam int SEL_STEP = 1;
    localparam int SEL_CH0  = 2;

    logic                    glob_q;
    logic                    glob_nxt;
    logic [STEP_W-1:0]       step_q;
    logic [STEP_W-1:0]       phase_q;
    logic signed [SAMP_W-1:0] sample;
    logic [NCH-1:0][1:0]     ch_mode;

    // ---------------- shared configuration ----------------
    assign glob_nxt = (cfg_we && cfg_sel == SEL_W'(SEL_GLOB)) ? cfg_wdata[0] : glob_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            glob_q <= 1'b0;
            step_q <= '0;
        end else begin
            glob_q <= glob_nxt;
            if (cfg_we && cfg_sel == SEL_W'(SEL_STEP)) begin
                step_q <= cfg_wdata[STEP_W-1:0];
            end
        end
    end

    cosgen_phase_acc u_acc (
        .clk   (clk),
        .rst   (rst),
        .run   (glob_q),
        .step  (step_q),
        .phase (phase_q)
    );

    cosgen_cos_lut u_lut (
        .ptop   (phase_q[STEP_W-1 -: PTOP_W]),
        .sample (sample)
    );

    // ---------------- channels ----------------
    for (genvar c = 0; c < NCH; c++) begin : g_ch
        ch_mode_e          mode_c;
        logic [CODE_W-1:0] code_c;
        logic              hit_c;

        assign hit_c = cfg_we && (cfg_sel == SEL_W'(SEL_CH0 + c));

        cosgen_chan u_chan (
            .clk       (clk),
            .rst       (rst),
            .glob_nxt  (glob_nxt),
            .cfg_hit   (hit_c),
            .cfg_en    (cfg_wdata[F_EN]),
            .cfg_scale (cfg_wdata[F_SCALE +: SCALE_W]),
            .cfg_phase (cfg_wdata[F_PHASE +: PHASE_W]),
            .cfg_off   (cfg_wdata[F_OFF +: CODE_W]),
            .dir_we    (dir_we[c]),
            .dir_code  (dir_code[c*CODE_W +: CODE_W]),
            .sample    (sample),
            .mode      (mode_c),
            .code      (code_c)
        );

        assign ch_mode[c]                 = mode_c;
        assign dac_code[c*CODE_W +: CODE_W] = code_c;
    end

endmodule

// File: rtl/cosgen_checker.sv
module cosgen_checker
    import cosgen_pkg::*;
#(
    parameter int NCH = 2
) (
    input logic                  clk,
    input logic                  rst,
    input logic [NCH-1:0]        dir_we,
    input logic [NCH*CODE_W-1:0] dir_code,
    input logic [NCH*CODE_W-1:0] dac_code,
    input logic                  glob_q,
    input logic [STEP_W-1:0]     step_q,
    input logic [STEP_W-1:0]     phase_q,
    input logic [NCH-1:0][1:0]   ch_mode
);

    // R1: reset leaves midscale codes, zero phase, switch off
    a_r1_reset_state: assert property (@(posedge clk)
        rst |=> (dac_code == {NCH{MIDSCALE}}) && (phase_q == '0) && !glob_q);

    // R2: accumulator advances by the step while running
    a_r2_phase_step: assert property (@(posedge clk) disable iff (rst)
        glob_q |=> (phase_q == STEP_W'($past(phase_q) + $past(step_q))));

    // R2: accumulator holds while stopped
    a_r2_phase_hold: assert property (@(posedge clk) disable iff (rst)
        !glob_q |=> $stable(phase_q));

    for (genvar c = 0; c < NCH; c++) begin : g_chk
        // R9: a direct write drops the channel into DIRECT
        a_r9_direct_mode: assert property (@(posedge clk) disable iff (rst)
            dir_we[c] |=> (ch_mode[c] == MODE_DIRECT));

        // R10: the written code appears one edge after capture
        a_r10_direct_latency: assert property (@(posedge clk) disable iff (rst)
            dir_we[c] |=> ##1 (dac_code[c*CODE_W +: CODE_W] ==
                               $past(dir_code[c*CODE_W +: CODE_W], 2)));

        // R11: TONE never held without the shared switch
        a_r11_tone_needs_glob: assert property (@(posedge clk) disable iff (rst)
            (ch_mode[c] == MODE_TONE) |-> glob_q);
    end

endmodule

bind cosgen_tone_top cosgen_checker #(.NCH(NCH)) u_chk (
    .clk      (clk),
    .rst      (rst),
    .dir_we   (dir_we),
    .dir_code (dir_code),
    .dac_code (dac_code),
    .glob_q   (glob_q),
    .step_q   (step_q),
    .phase_q  (phase_q),
    .ch_mode  (ch_mode)
);

// File: tb/cosgen_tone_top_bench.sv
module cosgen_tone_top_bench;

    localparam int  NCH = 2;
    localparam real PI  = 3.14159265358979;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cfg_we = 1'b0;
    logic [1:0]  cfg_sel = '0;
    logic [15:0] cfg_wdata = '0;
    logic [1:0]  dir_we = '0;
    logic [15:0] dir_code = '0;
    logic [15:0] dac_code;

    int checks = 0;
    int errors = 0;
    string cur_req = "R1";

    // behavioural reference state
    int m_acc, m_step, m_glob;
    int m_en[NCH], m_sc[NCH], m_ph[NCH], m_off[NCH], m_dir[NCH], m_out[NCH];

    cosgen_tone_top #(.NCH(NCH)) u_cosgen_tone_top (
        .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
        .cfg_wdata(cfg_wdata), .dir_we(dir_we), .dir_code(dir_code),
        .dac_code(dac_code)
    );

    always #2 clk = ~clk;

    function automatic int ref_sample(int acc);
        int  k;
        real v;
        k = acc / 1024;
        v = 127.0 * $cos(2.0 * PI * (real'(k) + 0.5) / 64.0);
        if (v >= 0.0) return $rtoi(v + 0.5);
        return -$rtoi(-v + 0.5);
    endfunction

    function automatic int ref_code(int c);
        int s;
        s = ref_sample(m_acc);
        s = s >>> m_sc[c];
        if (m_ph[c] == 3) s = -s;
        s = s + m_off[c] + 128;
        if (s < 0) s = 0;
        if (s > 255) s = 255;
        return s;
    endfunction

    // reference model, advanced on the same edge as the design
    always @(posedge clk) begin
        if (rst) begin
            m_acc = 0; m_step = 0; m_glob = 0;
            for (int c = 0; c < NCH; c++) begin
                m_en[c] = 0; m_sc[c] = 0; m_ph[c] = 2; m_off[c] = 0;
                m_dir[c] = 128; m_out[c] = 128;
            end
        end else begin
            for (int c = 0; c < NCH; c++)
                m_out[c] = (m_glob != 0 && m_en[c] != 0) ? ref_code(c) : m_dir[c];
            if (m_glob != 0) m_acc = (m_acc + m_step) % 65536;
            if (cfg_we) begin
                if (cfg_sel == 2'd0) m_glob = int'(cfg_wdata[0]);
                else if (cfg_sel == 2'd1) m_step = int'(cfg_wdata);
                else begin
                    m_en [cfg_sel-2] = int'(cfg_wdata[0]);
                    m_sc [cfg_sel-2] = int'(cfg_wdata[2:1]);
                    m_ph [cfg_sel-2] = int'(cfg_wdata[4:3]);
                    m_off[cfg_sel-2] = int'($signed(cfg_wdata[15:8]));
                end
            end
            for (int c = 0; c < NCH; c++) begin
                if (dir_we[c]) begin
                    m_dir[c] = int'(dir_code[c*8 +: 8]);
                    m_en[c]  = 0;
                end
            end
        end
    end

    // every-cycle comparison, away from the active edge
    always @(negedge clk) begin
        for (int c = 0; c < NCH; c++) begin
            checks++;
            if (dac_code[c*8 +: 8] !== m_out[c][7:0]) begin
                errors++;
                $display("FAIL %s cycle compare ch%0d: actual %0d expected %0d",
                         cur_req, c, dac_code[c*8 +: 8], m_out[c]);
            end
        end
    end

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic wait_n(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic cfg(input logic [1:0] sel, input logic [15:0] data);
        cfg_we = 1'b1; cfg_sel = sel; cfg_wdata = data;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    function automatic logic [15:0] chw(input int en, input int sc, input int ph, input int off);
        return {8'(off), 3'b000, 2'(ph), 2'(sc), 1'(en)};
    endfunction

    initial begin
        #(200000 * 4);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        wait_n(2);
        rst = 1'b0;
        chk("R1 reset codes", int'(dac_code), 16'h8080);

        // R10 / R9: direct codes and their latency
        cur_req = "R9";
        dir_we = 2'b11; dir_code = 16'hC33C;
        @(negedge clk);
        dir_we = 2'b00;
        chk("R10 code not yet visible", int'(dac_code[7:0]), 8'h80);
        wait_n(1);
        chk("R9 ch0 direct", int'(dac_code[7:0]), 8'h3C);
        chk("R9 ch1 direct", int'(dac_code[15:8]), 8'hC3);

        // R3 / R8: channels armed while the shared switch is off
        cur_req = "R8";
        cfg(2'd2, chw(1, 0, 2, 127));
        cfg(2'd3, chw(1, 3, 2, 0));
        wait_n(1);
        chk("R8 armed ch0 shows direct", int'(dac_code[7:0]), 8'h3C);
        cur_req = "R7";
        cfg(2'd0, 16'h0001);
        wait_n(1);
        chk("R7 upper clamp", int'(dac_code[7:0]), 255);
        chk("R5 scale 3", int'(dac_code[15:8]), 143);

        cur_req = "R6";
        cfg(2'd2, chw(1, 1, 3, 0));
        cfg(2'd3, chw(1, 0, 3, -128));
        wait_n(1);
        chk("R6 inverted half scale", int'(dac_code[7:0]), 65);
        chk("R7 lower clamp", int'(dac_code[15:8]), 0);
        cfg(2'd2, chw(1, 0, 0, 0));
        wait_n(1);
        chk("R6 phase field 0 not inverted", int'(dac_code[7:0]), 255);

        // R11: pause and resume through the shared switch
        cur_req = "R11";
        cfg(2'd0, 16'h0000);
        wait_n(1);
        chk("R11 pause to direct code", int'(dac_code[7:0]), 8'h3C);
        cfg(2'd0, 16'h0001);
        wait_n(1);
        chk("R11 resume tone", int'(dac_code[7:0]), 255);

        // R9: direct write wins over a same-cycle enable
        cur_req = "R9";
        cfg_we = 1'b1; cfg_sel = 2'd3; cfg_wdata = chw(1, 0, 2, 0);
        dir_we = 2'b10; dir_code = 16'h5500;
        @(negedge clk);
        cfg_we = 1'b0; dir_we = 2'b00;
        wait_n(1);
        chk("R9 direct priority", int'(dac_code[15:8]), 8'h55);
        wait_n(3);
        chk("R9 stays direct", int'(dac_code[15:8]), 8'h55);

        // R4 / R2 / R5: sweeps checked every cycle against the model
        cur_req = "R4";
        cfg(2'd2, chw(1, 0, 2, 0));
        cfg(2'd3, chw(1, 2, 3, 10));
        cfg(2'd1, 16'd1024);
        wait_n(140);
        cur_req = "R2";
        cfg(2'd1, 16'h1234);
        wait_n(300);
        cfg(2'd0, 16'h0000);
        wait_n(20);
        cfg(2'd0, 16'h0001);
        wait_n(60);
        cfg(2'd1, 16'hFFFF);
        wait_n(100);
        cur_req = "R5";
        cfg(2'd2, chw(1, 3, 2, -20));
        cfg(2'd3, chw(1, 1, 2, 100));
        cfg(2'd1, 16'd523);
        wait_n(300);

        // R1: reset in mid-run
        cur_req = "R1";
        rst = 1'b1;
        wait_n(1);
        rst = 1'b0;
        chk("R1 mid-run reset", int'(dac_code), 16'h8080);
        wait_n(5);
        chk("R1 idle after reset", int'(dac_code), 16'h8080);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule